// File: doc/BRIEF.md
# Ternary Differential Dot-Product Sign Unit

This block is a cycle-level digital model of a differential in-memory compute column. Each column pair stores one weight per input on two complementary bit lines. Each input drives word lines. The products of all active input and weight pairs are summed as a signed differential difference, and that difference is then reduced to one decision bit, as a binarized network layer needs. The unit serves as a reference and scoreboard companion for the analog array. Analog margin and switch feedthrough are not modelled.

Two operand modes share one row vector. In ternary mode, two adjacent rows carry one ternary input, so the default 128 rows give 64 ternary inputs per pair. In binary mode, every row is a separate on/off input and each column weight is a single sign bit. A start strobe captures the operands. The signed difference of every column pair and its sign appear four cycles later. A new operation may start on every cycle.

Top module: `tdot_sign_unit`

## Requirements
- R1: In ternary mode, input j uses bits [2j+1:2j] of the activation vector, and its weight in a column uses the same bits of that column's weight slice. The codes are 2'b10 for +1, 2'b01 for -1 and 2'b00 for 0.
- R2: In ternary mode, the sum of a column is the total of 2·a·w over all N_IN inputs. A +1 product adds +2, a -1 product adds -2, and any product with a zero adds nothing.
- R3: The signed sum of each column is N_COL slices of SW bits, two's complement. It holds every reachable value without wrapping: ±2·N_IN in ternary mode (±128 by default) and ±4·N_IN in binary mode (±256 by default).
- R4: The sign bit of a column is 1 only when its sum is strictly positive. A sum of zero gives 0.
- R5: In binary mode, row r is active when activation bit r is 1. Weight bit r of a column stands for +1 when set and -1 when clear. An active row adds +2 or -2 to that column, and an inactive row adds nothing.
- R6: In ternary mode, code 2'b11 in any activation pair or weight pair raises the illegal flag of that result. The offending operand counts as zero.
- R7: An operation whose start strobe is high in cycle t gives valid_o high in cycle t+4 only. valid_o is a one-cycle pulse.
- R8: Operations started in consecutive cycles produce their own results in consecutive cycles, and neither disturbs the other.
- R9: During and right after reset, valid_o, every sign bit, every sum and the illegal flag are 0.
- R10: Sign, sum and illegal outputs keep their values in every cycle where valid_o is low.
- R11: A binary-mode result never raises the illegal flag, whatever the operand bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Captures the operands on this edge and begins an operation |
| bin_mode_i | input | 1 | 1 selects binary rows, 0 selects ternary pairs |
| act_i | input | 2·N_IN (128) | Activation rows |
| wgt_i | input | N_COL·2·N_IN (512) | Weight rows; column c occupies bits [c·2·N_IN +: 2·N_IN] |
| valid_o | output | 1 | One-cycle result strobe |
| sign_o | output | N_COL (4) | Decision bit per column pair |
| sum_o | output | N_COL·SW (40) | Signed differential sum per column; column c at [c·SW +: SW] |
| illegal_o | output | 1 | An illegal ternary code was present in the operands |

## Verification
The checker assumes that start_i and bin_mode_i are 0 throughout reset and are driven to known values afterwards. Its latency and mode tracking begins from that cleared state. The bench changes all inputs only on the falling edge and keeps start low while reset is held. Code 2'b11 goes only to the scenarios that check the illegal flag, or into binary mode, where it has no special meaning.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

   localparam logic [1:0] TC_ZERO = 2'b00;
   localparam logic [1:0] TC_POS  = 2'b10;
   localparam logic [1:0] TC_NEG  = 2'b01;
   localparam logic [1:0] TC_BAD  = 2'b11;

   typedef logic signed [2:0] contrib_t;

   // differential contribution of one ternary input and weight pair
   function automatic contrib_t tern_prod(input logic [1:0] a, input logic [1:0] w);
      logic a_nz, w_nz, neg;
      a_nz = (a == TC_POS) || (a == TC_NEG);
      w_nz = (w == TC_POS) || (w == TC_NEG);
      neg  = (a == TC_NEG) ^ (w == TC_NEG);
      if (a_nz && w_nz) return neg ? -3'sd2 : 3'sd2;
      return 3'sd0;
   endfunction

   // differential contribution of one binary row
   function automatic contrib_t bin_prod(input logic a, input logic w);
      if (!a) return 3'sd0;
      return w ? 3'sd2 : -3'sd2;
   endfunction

endpackage

// File: rtl/tdp_capture.sv
module tdp_capture #(
   parameter int ROWS  = 128,
   parameter int COLS  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic                 bin_mode_i,
   input  logic [ROWS-1:0]      act_i,
   input  logic [COLS*ROWS-1:0] wgt_i,
   output logic                 vld_o,
   output logic                 mode_o,
   output logic                 ill_o,
   output logic [ROWS-1:0]      act_o,
   output logic [COLS*ROWS-1:0] wgt_o
);
   import tdp_pkg::*;

   localparam int PAIRS = ROWS / 2;

   logic bad_code;

   always_comb begin
      bad_code = 1'b0;
      for (int j = 0; j < PAIRS; j++) begin
         if (act_i[2*j +: 2] == TC_BAD) bad_code = 1'b1;
         for (int c = 0; c < COLS; c++) begin
            if (wgt_i[c*ROWS + 2*j +: 2] == TC_BAD) bad_code = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         mode_o <= 1'b0;
         ill_o  <= 1'b0;
         act_o  <= '0;
         wgt_o  <= '0;
      end else begin
         vld_o <= start_i;
         if (start_i) begin
            mode_o <= bin_mode_i;
            ill_o  <= bad_code && !bin_mode_i;
            act_o  <= act_i;
            wgt_o  <= wgt_i;
         end
      end
   end

endmodule

// File: rtl/tdp_column.sv
module tdp_column #(
   parameter int N_IN = 64,
   parameter int SW   = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_i,
   input  logic [2*N_IN-1:0]    act_i,
   input  logic [2*N_IN-1:0]    wgt_i,
   input  logic                 load_i,
   output logic                 sign_o,
   output logic signed [SW-1:0] sum_o
);
   import tdp_pkg::*;

   localparam int ROWS = 2 * N_IN;

   contrib_t prod_d [ROWS];
   contrib_t prod_q [ROWS];
   logic signed [SW-1:0] acc_d;
   logic signed [SW-1:0] acc_q;

   // per row product: a row below N_IN also indexes a ternary pair
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      if (r < N_IN) begin : g_dual
         always_comb
            prod_d[r] = mode_i ? bin_prod(act_i[r], wgt_i[r])
                               : tern_prod(act_i[2*r +: 2], wgt_i[2*r +: 2]);
      end else begin : g_bin_only
         always_comb
            prod_d[r] = mode_i ? bin_prod(act_i[r], wgt_i[r]) : 3'sd0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) prod_q[r] <= 3'sd0;
      end else begin
         for (int r = 0; r < ROWS; r++) prod_q[r] <= prod_d[r];
      end
   end

   always_comb begin
      acc_d = '0;
      for (int r = 0; r < ROWS; r++)
         acc_d = acc_d + {{(SW-3){prod_q[r][2]}}, prod_q[r]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
   end

   // decision stage, models the compute sense amplifier
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sign_o <= 1'b0;
         sum_o  <= '0;
      end else if (load_i) begin
         sign_o <= (acc_q > 0);
         sum_o  <= acc_q;
      end
   end

endmodule

// File: rtl/tdot_sign_unit.sv
module tdot_sign_unit #(
   parameter int N_IN  = 64,
   parameter int N_COL = 4,
   localparam int ROWS = 2 * N_IN,
   localparam int SW   = $clog2(2 * ROWS + 1) + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic                  bin_mode_i,
   input  logic [ROWS-1:0]       act_i,
   input  logic [N_COL*ROWS-1:0] wgt_i,
   output logic                  valid_o,
   output logic [N_COL-1:0]      sign_o,
   output logic [N_COL*SW-1:0]   sum_o,
   output logic                  illegal_o
);

   if (N_IN < 1) begin : g_bad_nin
      $error("tdot_sign_unit: N_IN must be at least 1");
   end
   if (N_COL < 1) begin : g_bad_ncol
      $error("tdot_sign_unit: N_COL must be at least 1");
   end

   logic                  v1, v2, v3, v4;
   logic                  mode1;
   logic                  ill1, ill2, ill3, ill4;
   logic [ROWS-1:0]       act1;
   logic [N_COL*ROWS-1:0] wgt1;

   tdp_capture #(.ROWS(ROWS), .COLS(N_COL)) u_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .bin_mode_i (bin_mode_i),
      .act_i      (act_i),
      .wgt_i      (wgt_i),
      .vld_o      (v1),
      .mode_o     (mode1),
      .ill_o      (ill1),
      .act_o      (act1),
      .wgt_o      (wgt1)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v2   <= 1'b0;
         v3   <= 1'b0;
         v4   <= 1'b0;
         ill2 <= 1'b0;
         ill3 <= 1'b0;
         ill4 <= 1'b0;
      end else begin
         v2   <= v1;
         v3   <= v2;
         v4   <= v3;
         ill2 <= ill1;
         ill3 <= ill2;
         if (v3) ill4 <= ill3;
      end
   end

   for (genvar c = 0; c < N_COL; c++) begin : g_col
      logic signed [SW-1:0] col_sum;
      tdp_column #(.N_IN(N_IN), .SW(SW)) u_col (
         .clk    (clk),
         .rst_n  (rst_n),
         .mode_i (mode1),
         .act_i  (act1),
         .wgt_i  (wgt1[c*ROWS +: ROWS]),
         .load_i (v3),
         .sign_o (sign_o[c]),
         .sum_o  (col_sum)
      );
      assign sum_o[c*SW +: SW] = col_sum;
   end

   assign valid_o   = v4;
   assign illegal_o = ill4;

endmodule

// File: rtl/tdp_checker.sv
module tdp_checker #(
   parameter int N_IN  = 64,
   parameter int N_COL = 4,
   localparam int ROWS = 2 * N_IN,
   localparam int SW   = $clog2(2 * ROWS + 1) + 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start_i,
   input logic                  bin_mode_i,
   input logic                  valid_o,
   input logic [N_COL-1:0]      sign_o,
   input logic [N_COL*SW-1:0]   sum_o,
   input logic                  illegal_o
);

   logic [3:0] st_sh;
   logic [3:0] md_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_sh <= '0;
         md_sh <= '0;
      end else begin
         st_sh <= {st_sh[2:0], start_i};
         md_sh <= {md_sh[2:0], bin_mode_i};
      end
   end

   // R7: result strobe follows the start strobe by exactly four cycles
   p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o == st_sh[3]);

   // R10: outputs frozen between results
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(sign_o) && $stable(sum_o) && $stable(illegal_o)));

   // R11: binary results never flagged
   p_bin_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && md_sh[3]) |-> !illegal_o);

   for (genvar c = 0; c < N_COL; c++) begin : g_chk
      logic signed [SW-1:0] s;
      assign s = sum_o[c*SW +: SW];

      // R4: decision is strict positivity of the sum
      p_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
         valid_o |-> (sign_o[c] == (s > 0)));

      // R2: every contribution is an even number of units
      p_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
         valid_o |-> (s[0] == 1'b0));

      // R3: ternary results stay within the ternary range
      p_tern_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_o && !md_sh[3]) |-> ((s <= 2 * N_IN) && (s >= -2 * N_IN)));

      // R3: binary results stay within the row range
      p_bin_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_o && md_sh[3]) |-> ((s <= 2 * ROWS) && (s >= -2 * ROWS)));
   end

endmodule

bind tdot_sign_unit tdp_checker #(.N_IN(N_IN), .N_COL(N_COL)) u_tdp_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .bin_mode_i (bin_mode_i),
   .valid_o    (valid_o),
   .sign_o     (sign_o),
   .sum_o      (sum_o),
   .illegal_o  (illegal_o)
);

// File: tb/tdot_sign_unit_bench.sv
module tdot_sign_unit_bench;

   localparam int N_IN  = 64;
   localparam int N_COL = 4;
   localparam int ROWS  = 2 * N_IN;
   localparam int SW    = $clog2(2 * ROWS + 1) + 1;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  start_i = 1'b0;
   logic                  bin_mode_i = 1'b0;
   logic [ROWS-1:0]       act_i = '0;
   logic [N_COL*ROWS-1:0] wgt_i;
   logic                  valid_o;
   logic [N_COL-1:0]      sign_o;
   logic [N_COL*SW-1:0]   sum_o;
   logic                  illegal_o;

   logic [ROWS-1:0] wgt [N_COL];

   int n_checks = 0;
   int n_fails  = 0;
   int exp_sum [N_COL];
   bit exp_ill;
   int exp_sum_b [N_COL];
   bit exp_ill_b;

   always #5 clk = ~clk;

   always_comb begin
      for (int c = 0; c < N_COL; c++) wgt_i[c*ROWS +: ROWS] = wgt[c];
   end

   tdot_sign_unit #(.N_IN(N_IN), .N_COL(N_COL)) u_tdot_sign_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .bin_mode_i (bin_mode_i),
      .act_i      (act_i),
      .wgt_i      (wgt_i),
      .valid_o    (valid_o),
      .sign_o     (sign_o),
      .sum_o      (sum_o),
      .illegal_o  (illegal_o)
   );

   // ---------------- reference model from the requirements ----------------
   function automatic int tval(logic [1:0] code);
      if (code == 2'b10) return 1;
      if (code == 2'b01) return -1;
      return 0;
   endfunction

   function automatic logic [1:0] tcode(int v);
      if (v > 0) return 2'b10;
      if (v < 0) return 2'b01;
      return 2'b00;
   endfunction

   function automatic int model_sum(bit md, logic [ROWS-1:0] a, logic [ROWS-1:0] w);
      int s = 0;
      if (md) begin
         for (int r = 0; r < ROWS; r++) if (a[r]) s += w[r] ? 2 : -2;
      end else begin
         for (int j = 0; j < N_IN; j++) s += 2 * tval(a[2*j +: 2]) * tval(w[2*j +: 2]);
      end
      return s;
   endfunction

   function automatic bit model_ill(bit md, logic [ROWS-1:0] a);
      bit f = 0;
      if (md) return 0;
      for (int j = 0; j < N_IN; j++) begin
         if (a[2*j +: 2] == 2'b11) f = 1;
         for (int c = 0; c < N_COL; c++) if (wgt[c][2*j +: 2] == 2'b11) f = 1;
      end
      return f;
   endfunction

   task automatic build_expect();
      for (int c = 0; c < N_COL; c++) exp_sum[c] = model_sum(bin_mode_i, act_i, wgt[c]);
      exp_ill = model_ill(bin_mode_i, act_i);
   endtask

   // ---------------- checking helpers ----------------
   task automatic check(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_results(string req);
      for (int c = 0; c < N_COL; c++) begin
         int got = $signed(sum_o[c*SW +: SW]);
         check(req, $sformatf("sum col%0d", c), got, exp_sum[c]);
         check("R4", $sformatf("sign col%0d", c), int'(sign_o[c]), int'(exp_sum[c] > 0));
      end
      check("R6", "illegal flag", int'(illegal_o), int'(exp_ill));
   endtask

   // drive at a falling edge, check valid at t+3 (low), t+4 (high), t+5 (low, held)
   task automatic run_op(string req);
      build_expect();
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R7", "valid early", int'(valid_o), 0);
      @(negedge clk);
      check("R7", "valid at t+4", int'(valid_o), 1);
      check_results(req);
      @(negedge clk);
      check("R7", "valid one cycle", int'(valid_o), 0);
      check_results("R10");
   endtask

   task automatic clear_ops(bit md);
      bin_mode_i = md;
      act_i = '0;
      for (int c = 0; c < N_COL; c++) wgt[c] = '0;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      check("R9", "valid after reset", int'(valid_o), 0);
      check("R9", "sign after reset", int'(sign_o), 0);
      check("R9", "sum after reset", int'(sum_o != '0), 0);
      check("R9", "illegal after reset", int'(illegal_o), 0);
   endtask

   task automatic t_ternary_extremes();
      clear_ops(0);
      for (int j = 0; j < N_IN; j++) begin
         act_i[2*j +: 2]  = 2'b10;
         wgt[0][2*j +: 2] = 2'b10;
         wgt[1][2*j +: 2] = 2'b01;
         wgt[2][2*j +: 2] = 2'b00;
         wgt[3][2*j +: 2] = (j % 2 == 0) ? 2'b10 : 2'b01;
      end
      run_op("R3");
      check("R3", "ternary max col0", $signed(sum_o[0 +: SW]), 2 * N_IN);
      check("R4", "tie col3 sign", int'(sign_o[3]), 0);
   endtask

   task automatic t_ternary_mixed();
      clear_ops(0);
      for (int j = 0; j < N_IN; j++) begin
         act_i[2*j +: 2] = tcode(((j * 5 + 1) % 3) - 1);
         for (int c = 0; c < N_COL; c++) wgt[c][2*j +: 2] = tcode(((j * 7 + c * 11) % 3) - 1);
      end
      run_op("R1");
   endtask

   task automatic t_single_product();
      clear_ops(0);
      act_i[2*9 +: 2]  = 2'b01;
      wgt[0][2*9 +: 2] = 2'b01;
      wgt[1][2*9 +: 2] = 2'b10;
      wgt[2][2*8 +: 2] = 2'b10;
      run_op("R2");
      check("R2", "single +2", $signed(sum_o[0 +: SW]), 2);
      check("R4", "single -2 sign", int'(sign_o[1]), 0);
   endtask

   task automatic t_illegal();
      clear_ops(0);
      for (int j = 0; j < N_IN; j++) begin
         act_i[2*j +: 2] = 2'b10;
         for (int c = 0; c < N_COL; c++) wgt[c][2*j +: 2] = 2'b10;
      end
      act_i[2*3 +: 2]   = 2'b11;
      wgt[2][2*10 +: 2] = 2'b11;
      run_op("R6");
      check("R6", "bad input counts zero", $signed(sum_o[0 +: SW]), 2 * (N_IN - 1));
      check("R6", "bad weight counts zero", $signed(sum_o[2*SW +: SW]), 2 * (N_IN - 2));
   endtask

   task automatic t_binary();
      clear_ops(1);
      act_i  = '1;
      wgt[0] = '1;
      wgt[1] = '0;
      for (int r = 0; r < ROWS; r++) wgt[2][r] = r[0];
      for (int r = 0; r < ROWS; r++) wgt[3][r] = (r % 3 == 0);
      run_op("R5");
      check("R3", "binary max", $signed(sum_o[0 +: SW]), 2 * ROWS);
      check("R3", "binary min", $signed(sum_o[SW +: SW]), -2 * ROWS);
      check("R11", "binary no flag", int'(illegal_o), 0);
   endtask

   task automatic t_binary_sparse();
      clear_ops(1);
      for (int r = 0; r < ROWS; r++) begin
         act_i[r] = (r % 4 != 1);
         for (int c = 0; c < N_COL; c++) wgt[c][r] = ((r + c) % 5 < 2);
      end
      run_op("R5");
   endtask

   task automatic t_pipeline();
      clear_ops(0);
      for (int j = 0; j < N_IN; j++) begin
         act_i[2*j +: 2] = tcode((j % 3) - 1);
         for (int c = 0; c < N_COL; c++) wgt[c][2*j +: 2] = tcode(((j + c) % 3) - 1);
      end
      build_expect();
      exp_sum_b = exp_sum;
      exp_ill_b = exp_ill;
      start_i = 1'b1;
      @(negedge clk);
      bin_mode_i = 1'b1;
      for (int r = 0; r < ROWS; r++) begin
         act_i[r] = (r % 2 == 0);
         for (int c = 0; c < N_COL; c++) wgt[c][r] = (r % (c + 2) == 0);
      end
      build_expect();
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R8", "first valid", int'(valid_o), 1);
      for (int c = 0; c < N_COL; c++)
         check("R8", $sformatf("first sum col%0d", c), $signed(sum_o[c*SW +: SW]), exp_sum_b[c]);
      check("R8", "first illegal", int'(illegal_o), int'(exp_ill_b));
      @(negedge clk);
      check("R8", "second valid", int'(valid_o), 1);
      check_results("R8");
      @(negedge clk);
      check("R8", "pipe drained", int'(valid_o), 0);
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      for (int c = 0; c < N_COL; c++) wgt[c] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ternary_extremes();
      t_ternary_mixed();
      t_single_product();
      t_illegal();
      t_binary();
      t_binary_sparse();
      t_pipeline();
      @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule